// File: doc/BRIEF.md
# Approximate Ripple-Carry Adder

This block adds two N-bit operands and a carry-in through a chain of one-bit cells. The cells at the bottom of the chain are approximate cells and those above them are exact full adders. An approximate cell trades accuracy in the least significant positions for a much simpler cell. It passes its A operand straight up as the carry and forms its sum with one gated term. The block is purely combinational.

Three parameters set the configuration. `WIDTH` is the operand width. `APPROX_BITS` is the number of approximate positions, counted upward from bit 0. `CELL_VARIANT` picks the approximate cell function. Variant 1 gates A XNOR B with the incoming carry. Variant 2 gates A XOR B with the inverted incoming carry. Variant 3 is a drive-strength flavour of variant 2 and has the same logic function. The block is meant for the low-order part of wider arithmetic such as partial-product reduction, where small errors in the low bits are acceptable.

Top module: `approx_rca`

## Requirements
- R1: In every approximate position i, the carry passed to position i+1 equals opA[i], regardless of opB[i] and of the incoming carry.
- R2: With CELL_VARIANT 1, an approximate position's sum bit equals (incoming carry) AND NOT(opA[i] XOR opB[i]), so it is 0 whenever the incoming carry is 0. A lone cell of this variant differs from an exact full adder on 3 of the 8 input rows.
- R3: With CELL_VARIANT 2, an approximate position's sum bit equals NOT(incoming carry) AND (opA[i] XOR opB[i]), so it is 0 whenever the incoming carry is 1.
- R4: CELL_VARIANT 3 produces exactly the same sumOut and carryOut as CELL_VARIANT 2 for every input.
- R5: The positions from APPROX_BITS up to WIDTH-1 form an exact ripple adder. Their input carry is the carry out of position APPROX_BITS-1, or carryIn when APPROX_BITS is 0. Together with carryOut they hold the exact sum of the upper operand slices plus that carry.
- R6: With APPROX_BITS = 0, {carryOut, sumOut} equals opA + opB + carryIn for every input.
- R7: With APPROX_BITS = WIDTH, every position is approximate, and carryOut equals opA[WIDTH-1].
- R8: APPROX_BITS values from 0 up to WIDTH elaborate. A value above WIDTH, or a CELL_VARIANT outside 1 to 3, stops elaboration with an error.
- R9: A single variant-2 cell gives a result different from an exact full adder on exactly 4 of the 8 input rows, an error rate of 0.5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand; in approximate positions, also the source of the carry |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum bits, approximate in the low APPROX_BITS positions |
| carryOut | output | 1 | Carry out of the top position |

## Verification
The assertions assume that all inputs are two-valued and settled when checked. The block is combinational, so every evaluation is a complete input state, and no input sequence is illegal. The stimulus changes operands only on clock edges and compares results half a period later. It sweeps every operand and carry combination on the 4-bit configurations. On the 8- and 16-bit configurations it uses hand-picked corners, including carries that cross the boundary between the approximate and exact regions, plus pseudo-random values.

// File: rtl/approx_rca_pkg.sv
`timescale 1ns/1ps
package approx_rca_pkg;

  // Logic function of an approximate cell.
  typedef enum logic [1:0] {
    CELL_XNOR_GATED = 2'd1,  // sum = cin & ~(a ^ b)
    CELL_XOR_BLOCKED = 2'd2  // sum = ~cin & (a ^ b)
  } cellKind_e;

  // Variant 3 differs only in drive strength, so it uses the variant 2 function.
  function automatic cellKind_e resolveKind(input int variantSel);
    return (variantSel == 1) ? CELL_XNOR_GATED : CELL_XOR_BLOCKED;
  endfunction

endpackage

// File: rtl/exact_fa_cell.sv
`timescale 1ns/1ps
module exact_fa_cell (
  input  logic aI,
  input  logic bI,
  input  logic cI,
  output logic sumO,
  output logic coutO
);
  logic halfSum;

  always_comb begin
    halfSum = aI ^ bI;
    sumO    = halfSum ^ cI;
    coutO   = (aI & bI) | (cI & halfSum);
  end
endmodule

// File: rtl/approx_fa_cell.sv
`timescale 1ns/1ps
module approx_fa_cell
  import approx_rca_pkg::*;
#(
  parameter cellKind_e KIND = CELL_XNOR_GATED
) (
  input  logic aI,
  input  logic bI,
  input  logic cI,
  output logic sumO,
  output logic coutO
);
  // The carry comes from the A operand alone.
  assign coutO = aI;

  generate
    if (KIND == CELL_XNOR_GATED) begin : g_xnor
      assign sumO = cI & ~(aI ^ bI);
      always_comb begin
        if (!cI) begin
          p_sum_zero_no_cin_r2 : assert (sumO == 1'b0)
            else $error("R2: sum must be 0 when carry-in is 0");
        end
      end
    end else begin : g_xor
      assign sumO = ~cI & (aI ^ bI);
      always_comb begin
        if (cI) begin
          p_sum_zero_with_cin_r3 : assert (sumO == 1'b0)
            else $error("R3: sum must be 0 when carry-in is 1");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/approx_rca_chain.sv
`timescale 1ns/1ps
module approx_rca_chain
  import approx_rca_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned APPROX_BITS = 4,
  parameter cellKind_e   KIND        = CELL_XNOR_GATED
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumVec,
  output logic             carryTop
);
  localparam int unsigned EXACT_W = WIDTH - APPROX_BITS;

  logic [WIDTH:0] carryChain;

  assign carryChain[0] = carryIn;
  assign carryTop      = carryChain[WIDTH];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < APPROX_BITS) begin : g_approx
        approx_fa_cell #(.KIND(KIND)) cell_i (
          .aI   (opA[i]),
          .bI   (opB[i]),
          .cI   (carryChain[i]),
          .sumO (sumVec[i]),
          .coutO(carryChain[i+1])
        );
        always_comb begin
          p_carry_from_a_r1 : assert (carryChain[i+1] == opA[i])
            else $error("R1: approximate carry must follow operand A");
        end
      end else begin : g_exact
        exact_fa_cell cell_i (
          .aI   (opA[i]),
          .bI   (opB[i]),
          .cI   (carryChain[i]),
          .sumO (sumVec[i]),
          .coutO(carryChain[i+1])
        );
      end
    end

    if (EXACT_W > 0) begin : g_upper_check
      logic [EXACT_W:0] upperRef;
      always_comb begin
        upperRef = {1'b0, opA[WIDTH-1:APPROX_BITS]}
                 + {1'b0, opB[WIDTH-1:APPROX_BITS]}
                 + {{EXACT_W{1'b0}}, carryChain[APPROX_BITS]};
        p_upper_exact_r5 : assert ({carryChain[WIDTH], sumVec[WIDTH-1:APPROX_BITS]} == upperRef)
          else $error("R5: exact region disagrees with arithmetic sum");
      end
    end
  endgenerate
endmodule

// File: rtl/approx_rca.sv
`timescale 1ns/1ps
module approx_rca
  import approx_rca_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned APPROX_BITS  = 4,
  parameter int          CELL_VARIANT = 1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam cellKind_e KIND = resolveKind(CELL_VARIANT);

  // R8: reject illegal configurations at elaboration.
  generate
    if (APPROX_BITS > WIDTH) begin : g_bad_count
      $error("approx_rca: APPROX_BITS exceeds WIDTH");
    end
    if (CELL_VARIANT < 1 || CELL_VARIANT > 3) begin : g_bad_variant
      $error("approx_rca: CELL_VARIANT must be 1, 2 or 3");
    end
  endgenerate

  approx_rca_chain #(
    .WIDTH      (WIDTH),
    .APPROX_BITS(APPROX_BITS),
    .KIND       (KIND)
  ) chain_i (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumVec  (sumOut),
    .carryTop(carryOut)
  );
endmodule

// File: tb/approx_rca_tb_top.sv
`timescale 1ns/1ps
module approx_rca_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [15:0] opA16, opB16;
  logic        cin;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;

  // Main instance: 8 bits, 4 approximate, variant 1.
  logic [7:0] sum8;
  logic       cout8;
  approx_rca #(.WIDTH(8), .APPROX_BITS(4), .CELL_VARIANT(1)) dut_i (
    .opA(opA16[7:0]), .opB(opB16[7:0]), .carryIn(cin), .sumOut(sum8), .carryOut(cout8)
  );

  // 4-bit sweep: variant v+1, approximate bit count n.
  logic [3:0] s4 [2][5];
  logic       c4 [2][5];
  for (genvar v = 0; v < 2; v++) begin : g_var
    for (genvar n = 0; n <= 4; n++) begin : g_nab
      approx_rca #(.WIDTH(4), .APPROX_BITS(n), .CELL_VARIANT(v+1)) d4_i (
        .opA(opA16[3:0]), .opB(opB16[3:0]), .carryIn(cin),
        .sumOut(s4[v][n]), .carryOut(c4[v][n])
      );
    end
  end

  // 16-bit, half approximate, variants 2 and 3.
  logic [15:0] s16v2, s16v3;
  logic        c16v2, c16v3;
  approx_rca #(.WIDTH(16), .APPROX_BITS(8), .CELL_VARIANT(2)) d16v2_i (
    .opA(opA16), .opB(opB16), .carryIn(cin), .sumOut(s16v2), .carryOut(c16v2)
  );
  approx_rca #(.WIDTH(16), .APPROX_BITS(8), .CELL_VARIANT(3)) d16v3_i (
    .opA(opA16), .opB(opB16), .carryIn(cin), .sumOut(s16v3), .carryOut(c16v3)
  );

  // Single cells for the per-row error counts.
  logic s1v1, c1v1, s1v2, c1v2;
  approx_rca #(.WIDTH(1), .APPROX_BITS(1), .CELL_VARIANT(1)) d1v1_i (
    .opA(opA16[0]), .opB(opB16[0]), .carryIn(cin), .sumOut(s1v1), .carryOut(c1v1)
  );
  approx_rca #(.WIDTH(1), .APPROX_BITS(1), .CELL_VARIANT(2)) d1v2_i (
    .opA(opA16[0]), .opB(opB16[0]), .carryIn(cin), .sumOut(s1v2), .carryOut(c1v2)
  );

  // Reference built from the requirements: {carry, sum} in bits [w:0].
  function automatic logic [16:0] model(input int w, input int nab, input int kind,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic ci);
    logic c, s, nxt;
    logic [16:0] r;
    r = '0;
    c = ci;
    for (int i = 0; i < w; i++) begin
      if (i < nab) begin
        nxt = a[i];
        s = (kind == 1) ? (c & ~(a[i] ^ b[i])) : (~c & (a[i] ^ b[i]));
      end else begin
        s   = a[i] ^ b[i] ^ c;
        nxt = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
      r[i] = s;
      c = nxt;
    end
    r[w] = c;
    return r;
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)", tag, act, exp, opA16, opB16, cin);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(posedge clk);
    opA16 = a;
    opB16 = b;
    cin   = c;
    @(negedge clk);
  endtask

  task automatic test_zero_state();
    apply(16'h0, 16'h0, 1'b0);
    check("R5 zero inputs 8-bit", {8'h0, cout8, sum8}, 17'h0);
    check("R4 zero inputs 16-bit", {c16v2, s16v2}, 17'h0);
  endtask

  task automatic test_cell_rows();
    int wrong1 = 0;
    int wrong2 = 0;
    for (int row = 0; row < 8; row++) begin
      logic a, b, c;
      logic [1:0] exact;
      {a, b, c} = row[2:0];
      apply({15'h0, a}, {15'h0, b}, c);
      exact = {1'b0, a} + {1'b0, b} + {1'b0, c};
      check("R1 R2 variant1 cell row", {15'h0, c1v1, s1v1}, model(1, 1, 1, {15'h0, a}, {15'h0, b}, c));
      check("R1 R3 variant2 cell row", {15'h0, c1v2, s1v2}, model(1, 1, 2, {15'h0, a}, {15'h0, b}, c));
      if ({c1v1, s1v1} != exact) wrong1++;
      if ({c1v2, s1v2} != exact) wrong2++;
    end
    check("R2 variant1 wrong rows", 17'(wrong1), 17'd3);
    check("R9 variant2 wrong rows", 17'(wrong2), 17'd4);
  endtask

  task automatic test_nab_sweep();
    for (int vec = 0; vec < 512; vec++) begin
      apply({12'h0, vec[7:4]}, {12'h0, vec[3:0]}, vec[8]);
      for (int v = 0; v < 2; v++) begin
        for (int n = 0; n <= 4; n++) begin
          string tag;
          tag = (n == 0) ? "R6 exact 4-bit" : (n == 4) ? "R7 R8 all-approx 4-bit" : "R5 mixed 4-bit";
          check($sformatf("%s v%0d nab%0d", tag, v + 1, n), {12'h0, c4[v][n], s4[v][n]},
                model(4, n, v + 1, opA16, opB16, cin));
        end
        check("R7 carryOut equals top A bit", {16'h0, c4[v][4]}, {16'h0, opA16[3]});
      end
    end
  endtask

  task automatic test_wide8();
    logic [7:0] ca [6] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h08, 8'h7F};
    logic [7:0] cb [6] = '{8'hFF, 8'h01, 8'hF1, 8'h0F, 8'h08, 8'h80};
    for (int k = 0; k < 12; k++) begin
      apply({8'h0, ca[k % 6]}, {8'h0, cb[k % 6]}, k[0]);
      check("R5 8-bit corner", {8'h0, cout8, sum8}, model(8, 4, 1, opA16, opB16, cin));
    end
    for (int k = 0; k < 300; k++) begin
      apply({8'h0, 8'($urandom)}, {8'h0, 8'($urandom)}, 1'($urandom));
      check("R2 R5 8-bit random", {8'h0, cout8, sum8}, model(8, 4, 1, opA16, opB16, cin));
    end
  endtask

  task automatic test_wide16();
    apply(16'h0080, 16'h0000, 1'b0);  // carry into the exact region from A[7]
    check("R1 R5 16-bit boundary carry", {c16v2, s16v2}, model(16, 8, 2, opA16, opB16, cin));
    apply(16'hFFFF, 16'h0001, 1'b1);
    check("R5 16-bit ripple", {c16v2, s16v2}, model(16, 8, 2, opA16, opB16, cin));
    for (int k = 0; k < 300; k++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check("R3 R5 16-bit variant2", {c16v2, s16v2}, model(16, 8, 2, opA16, opB16, cin));
      check("R4 variant3 matches variant2", {c16v3, s16v3}, {c16v2, s16v2});
    end
  endtask

  initial begin
    opA16 = '0;
    opB16 = '0;
    cin   = 1'b0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    test_zero_state();
    test_cell_rows();
    test_nab_sweep();
    test_wide8();
    test_wide16();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule